// File: doc/BRIEF.md
# Four-Level Nested Interrupt Arbiter

This block gathers fifteen interrupt requests for a small processor core, masks them with per-source enables and a master enable, and decides which one goes to the core. Every source is placed on one of four priority levels. The block keeps a record of the levels whose service routines are running, so a request can interrupt a routine only when its level is strictly higher. Two of the fifteen sources come from external pins. Each pin has its own selectable detector, either level or falling-edge.

The core raises a boundary strobe at each instruction boundary. On that strobe the arbiter registers its choice, which gives a request flag, a 4-bit source index and a 2-bit level. The core accepts the request with `ack`, which records the level as active. A return strobe `reti` closes the innermost active level. A wake output tells a sleeping core that an enabled external pin is requesting service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source takes part in arbitration only when its bit in `src_en` is 1 and `glob_en` is 1.
- R2: The level of source i is `{prio_hi[i], prio_lo[i]}`. 3 is the highest level and 0 the lowest. Among eligible candidates, the highest level wins and its value appears on `irq_lvl`.
- R3: Among candidates on the same level, the lowest source index wins and appears on `irq_idx`.
- R4: Outputs `irq_out`, `irq_idx` and `irq_lvl` change only in the cycle after `boundary` or `ack` is high, and hold their values otherwise.
- R5: A choice is presented only if its level is strictly above the highest bit set in `active_lvls`. While bit 3 is set, nothing is presented.
- R6: `ack` while `irq_out` is 1 sets bit `irq_lvl` of `active_lvls` one cycle later. Any `ack` forces `irq_out` to 0 on the next cycle and overrides `boundary` in that cycle. `ack` while `irq_out` is 0 leaves `active_lvls` unchanged.
- R7: `reti` clears the highest set bit of `active_lvls`. When `reti` and an accepted `ack` occur together, the clear is applied first and the set second.
- R8: External pins are active-low and feed sources 0 and 1. With `ext_edge_mode[e]` set to 0, source e is requesting exactly while `ext_pin[e]` is 0, with no register delay.
- R9: With `ext_edge_mode[e]` set to 1, a registered sample of 1 followed by a current sample of 0 sets a request flag. The flag is cleared by an accepted `ack` whose `irq_idx` equals e, and a new edge in the same cycle wins over the clear. The flag is held at 0 in level mode. The sample register resets to 1.
- R10: `wake` is 1 exactly when `sleep` is 1 and some external source with its `src_en` bit set is requesting. `glob_en` has no effect on `wake`.
- R11: After synchronous reset, `irq_out` is 0, `active_lvls` is 0 and both edge flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 13 | Request lines of sources 2 to 14 (bit k is source k+2) |
| ext_pin | input | 2 | Active-low external interrupt pins for sources 0 and 1 |
| ext_edge_mode | input | 2 | Per pin: 1 selects falling-edge detection, 0 selects level |
| src_en | input | 15 | Per-source enable |
| glob_en | input | 1 | Master enable for all sources |
| prio_lo | input | 15 | Low bit of each source's level |
| prio_hi | input | 15 | High bit of each source's level |
| boundary | input | 1 | Instruction-boundary strobe that triggers arbitration |
| ack | input | 1 | Core accepts the presented request |
| reti | input | 1 | Core returns from the innermost routine |
| sleep | input | 1 | Core is in idle or power-down |
| irq_out | output | 1 | A request is presented to the core |
| irq_idx | output | 4 | Index of the presented source |
| irq_lvl | output | 2 | Level of the presented source |
| active_lvls | output | 4 | One bit per level with a routine in progress |
| wake | output | 1 | Wake-up request from an enabled external source |

## Verification
The bench targets ties on one level between sources far apart in index. A reversed scan would present the higher index. It checks preemption against an equal-level active routine. A design that compares with "greater or equal" would nest a routine inside itself. It runs `ack` and `reti` in the same cycle. Applying them in the wrong order erases the level just entered. It produces a new falling edge on the cycle of the acknowledge, where giving the clear priority loses that interrupt. It also holds `glob_en` low while sleeping, so that a wake path gated by the master enable would never wake the core.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NUM_SRC = 15;
    localparam int NUM_EXT = 2;
    localparam int NUM_LVL = 4;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int INT_SRC = NUM_SRC - NUM_EXT;

    typedef logic [IDX_W-1:0]   src_idx_t;
    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [NUM_LVL-1:0] lvl_mask_t;

    // Result of arbitration over all candidates
    typedef struct packed {
        logic     valid;
        src_idx_t idx;
        lvl_t     lvl;
    } grant_t;

    // Innermost level currently being serviced
    typedef struct packed {
        logic any;
        lvl_t lvl;
    } top_t;

    function automatic top_t find_top(lvl_mask_t m);
        top_t t;
        t = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (m[l]) begin
                t.any = 1'b1;
                t.lvl = lvl_t'(l);
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/irq_ext_detect.sv
module irq_ext_detect
    import prio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic pending
);

    logic pin_q;
    logic flag;
    logic fall;

    assign fall = pin_q & ~pin_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b1;
            flag  <= 1'b0;
        end else begin
            pin_q <= pin_n;
            if (!edge_mode)
                flag <= 1'b0;
            else if (fall)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end

    assign pending = edge_mode ? flag : ~pin_n;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] cand,
    input  logic [N-1:0] p_lo,
    input  logic [N-1:0] p_hi,
    output grant_t       best
);

    always_comb begin
        best = '0;
        // Scan downward so that on equal levels the lower index replaces
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i] && (!best.valid || lvl_t'({p_hi[i], p_lo[i]}) >= best.lvl)) begin
                best.valid = 1'b1;
                best.idx   = src_idx_t'(i);
                best.lvl   = lvl_t'({p_hi[i], p_lo[i]});
            end
        end
    end

endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack
    import prio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  lvl_t      push_lvl,
    input  logic      pop,
    output lvl_mask_t act,
    output top_t      top
);

    lvl_mask_t nxt;

    assign top = find_top(act);

    always_comb begin
        nxt = act;
        if (pop && top.any)
            nxt[top.lvl] = 1'b0;
        if (push)
            nxt[push_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            act <= '0;
        else
            act <= nxt;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [INT_SRC-1:0]   src_req,
    input  logic [NUM_EXT-1:0]   ext_pin,
    input  logic [NUM_EXT-1:0]   ext_edge_mode,
    input  logic [NUM_SRC-1:0]   src_en,
    input  logic                 glob_en,
    input  logic [NUM_SRC-1:0]   prio_lo,
    input  logic [NUM_SRC-1:0]   prio_hi,
    input  logic                 boundary,
    input  logic                 ack,
    input  logic                 reti,
    input  logic                 sleep,
    output logic                 irq_out,
    output logic [IDX_W-1:0]     irq_idx,
    output logic [LVL_W-1:0]     irq_lvl,
    output logic [NUM_LVL-1:0]   active_lvls,
    output logic                 wake
);

    logic [NUM_EXT-1:0] ext_pend;
    logic [NUM_SRC-1:0] all_req;
    logic [NUM_SRC-1:0] cand;
    logic               accept;
    grant_t             grant;
    top_t               top;
    logic               eligible;

    assign accept = ack & irq_out;

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
        irq_ext_detect u_det (
            .clk       (clk),
            .rst       (rst),
            .pin_n     (ext_pin[e]),
            .edge_mode (ext_edge_mode[e]),
            .clr       (accept && (irq_idx == src_idx_t'(e))),
            .pending   (ext_pend[e])
        );
    end

    assign all_req = {src_req, ext_pend};
    assign cand    = all_req & src_en & {NUM_SRC{glob_en}};

    irq_arbiter #(.N(NUM_SRC)) u_arb (
        .cand (cand),
        .p_lo (prio_lo),
        .p_hi (prio_hi),
        .best (grant)
    );

    irq_active_stack u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (accept),
        .push_lvl (irq_lvl),
        .pop      (reti),
        .act      (active_lvls),
        .top      (top)
    );

    assign eligible = grant.valid && (!top.any || (grant.lvl > top.lvl));

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out <= 1'b0;
            irq_idx <= '0;
            irq_lvl <= '0;
        end else if (ack) begin
            irq_out <= 1'b0;
        end else if (boundary) begin
            irq_out <= eligible;
            irq_idx <= grant.idx;
            irq_lvl <= grant.lvl;
        end
    end

    assign wake = sleep & |(ext_pend & src_en[NUM_EXT-1:0]);

endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker
    import prio_irq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               glob_en,
    input logic               boundary,
    input logic               ack,
    input logic               reti,
    input logic               sleep,
    input logic               irq_out,
    input logic [IDX_W-1:0]   irq_idx,
    input logic [LVL_W-1:0]   irq_lvl,
    input logic [NUM_LVL-1:0] active_lvls,
    input logic               wake
);

    assert_new_req_needs_glob_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> ($past(glob_en) && $past(boundary)));

    assert_hold_between_strobes_R4: assert property (@(posedge clk) disable iff (rst)
        (!boundary && !ack) |=> ($stable(irq_out) && $stable(irq_idx) && $stable(irq_lvl)));

    assert_strictly_above_active_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> (($past(active_lvls) >> irq_lvl) == '0));

    assert_ack_drops_request_R6: assert property (@(posedge clk) disable iff (rst)
        ack |=> !irq_out);

    assert_ack_marks_level_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_out) |=> active_lvls[$past(irq_lvl)]);

    assert_reti_pops_one_R7: assert property (@(posedge clk) disable iff (rst)
        (reti && !ack) |=> ($countones(active_lvls) + int'($past(active_lvls) != '0)
                            == $countones($past(active_lvls))));

    assert_wake_only_sleeping_R10: assert property (@(posedge clk) disable iff (rst)
        !sleep |-> !wake);

endmodule

bind prio_irq_ctrl irq_ctrl_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .glob_en     (glob_en),
    .boundary    (boundary),
    .ack         (ack),
    .reti        (reti),
    .sleep       (sleep),
    .irq_out     (irq_out),
    .irq_idx     (irq_idx),
    .irq_lvl     (irq_lvl),
    .active_lvls (active_lvls),
    .wake        (wake)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] src_req = '0;
    logic [1:0]  ext_pin = 2'b11;
    logic [1:0]  ext_edge_mode = 2'b00;
    logic [14:0] src_en = '1;
    logic        glob_en = 1'b1;
    logic [14:0] prio_lo = '0;
    logic [14:0] prio_hi = '0;
    logic        boundary = 1'b1;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        sleep = 1'b0;
    logic        irq_out;
    logic [3:0]  irq_idx;
    logic [1:0]  irq_lvl;
    logic [3:0]  active_lvls;
    logic        wake;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst(rst), .src_req(src_req), .ext_pin(ext_pin),
        .ext_edge_mode(ext_edge_mode), .src_en(src_en), .glob_en(glob_en),
        .prio_lo(prio_lo), .prio_hi(prio_hi), .boundary(boundary), .ack(ack),
        .reti(reti), .sleep(sleep), .irq_out(irq_out), .irq_idx(irq_idx),
        .irq_lvl(irq_lvl), .active_lvls(active_lvls), .wake(wake)
    );

    // ---------------- behavioural reference ----------------
    bit       m_pq[2];
    bit       m_fl[2];
    bit       m_out;
    int       m_idx, m_lvl;
    bit [3:0] m_act;

    function automatic int lvl_of(int i);
        return 2 * int'(prio_hi[i]) + int'(prio_lo[i]);
    endfunction

    function automatic bit pend_of(int i);
        if (i < 2) return ext_edge_mode[i] ? m_fl[i] : !ext_pin[i];
        return src_req[i-2];
    endfunction

    always @(posedge clk) begin : model
        int best, bl, top;
        bit nf[2];
        bit [3:0] na;
        if (rst) begin
            m_pq = '{1, 1}; m_fl = '{0, 0};
            m_out = 0; m_idx = 0; m_lvl = 0; m_act = '0;
        end else begin
            best = -1; bl = -1; top = -1;
            for (int l = 3; l >= 0; l--)
                for (int i = 0; i < 15; i++)
                    if (best < 0 && src_en[i] && glob_en && pend_of(i) && lvl_of(i) == l) begin
                        best = i; bl = l;
                    end
            for (int l = 0; l < 4; l++) if (m_act[l]) top = l;
            for (int e = 0; e < 2; e++) begin
                if (!ext_edge_mode[e]) nf[e] = 0;
                else if (m_pq[e] && !ext_pin[e]) nf[e] = 1;
                else if (ack && m_out && m_idx == e) nf[e] = 0;
                else nf[e] = m_fl[e];
            end
            na = m_act;
            if (reti && top >= 0) na[top] = 0;
            if (ack && m_out) na[m_lvl] = 1;
            if (ack) m_out = 0;
            else if (boundary) begin
                m_out = (best >= 0) && (bl > top);
                if (best >= 0) begin m_idx = best; m_lvl = bl; end
            end
            m_act = na;
            m_fl = nf;
            m_pq[0] = ext_pin[0]; m_pq[1] = ext_pin[1];
        end
    end

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit ew;
            ew = sleep && ((src_en[0] && pend_of(0)) || (src_en[1] && pend_of(1)));
            cmp("R1/R4/R5/R6 irq_out", irq_out, m_out);
            if (m_out) begin
                cmp("R3/R8/R9 irq_idx", irq_idx, m_idx);
                cmp("R2 irq_lvl", irq_lvl, m_lvl);
            end
            cmp("R6/R7 active_lvls", active_lvls, m_act);
            cmp("R10 wake", wake, ew);
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse_ack();
        ack = 1; tick(1); ack = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R11: reset state
        cmp("R11 irq_out at reset", irq_out, 0);
        cmp("R11 active_lvls at reset", active_lvls, 0);
        rst = 0; tick(1);
        cmp("R11 irq_out after reset", irq_out, 0);

        // R3: sources 4 and 9 on the same level
        src_req[2] = 1; src_req[7] = 1; tick(3);
        // R2: source 9 raised to level 2
        prio_hi[9] = 1; tick(3);
        // R1: master enable and own enable off
        glob_en = 0; tick(3); glob_en = 1; src_en[9] = 0; tick(3); src_en[9] = 1; tick(2);
        // R4: no boundary, priorities change but outputs hold
        boundary = 0; prio_hi[4] = 1; prio_lo[4] = 1; tick(4); boundary = 1; tick(2);
        // R6/R5: accept level 3, then everything else blocked
        pulse_ack(); tick(3);
        prio_hi[9] = 1; prio_lo[9] = 1; tick(3);
        // R5: equal level while level 2 active only
        reti = 1; tick(1); reti = 0;
        prio_hi[4] = 1; prio_lo[4] = 0; prio_lo[9] = 0; tick(2);
        pulse_ack(); tick(3);
        // R7: return together with accept
        prio_lo[9] = 1; tick(2); reti = 1; ack = 1; tick(1); reti = 0; ack = 0; tick(2);
        reti = 1; tick(3); reti = 0;
        src_req = '0; tick(2);
        // R8: level-mode pin 1
        ext_pin[1] = 0; tick(3); ext_pin[1] = 1; tick(2);
        // R9: edge mode pin 0, accept clears flag; new edge with accept keeps it
        ext_edge_mode[0] = 1; tick(1); ext_pin[0] = 0; tick(3);
        ext_pin[0] = 1; tick(1); ext_pin[0] = 0; ack = 1; tick(1); ack = 0; tick(3);
        pulse_ack(); reti = 1; tick(1); reti = 0; tick(2);
        // R10: sleeping with master enable off
        glob_en = 0; sleep = 1; ext_pin[0] = 1; tick(1); ext_pin[0] = 0; tick(3);
        ext_edge_mode[0] = 0; ext_pin[0] = 1; tick(2); ext_pin[1] = 0; tick(2);
        src_en[1] = 0; tick(2); src_en[1] = 1; sleep = 0; glob_en = 1; ext_pin = 2'b11; tick(2);

        // Mixed random traffic over all requirements
        for (int k = 0; k < 6000; k++) begin
            if (k % 500 == 0) begin
                prio_lo = 15'($urandom); prio_hi = 15'($urandom);
                src_en = 15'($urandom) | 15'($urandom);
                ext_edge_mode = 2'($urandom);
            end
            src_req  = 13'($urandom) & 13'($urandom) & 13'($urandom);
            ext_pin  = 2'($urandom) | 2'($urandom);
            glob_en  = ($urandom % 8) != 0;
            boundary = ($urandom % 2) == 0;
            ack      = ($urandom % 3) == 0;
            reti     = ($urandom % 6) == 0;
            sleep    = ($urandom % 4) == 0;
            tick(1);
        end
        ack = 0; reti = 0; tick(2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule